// File: doc/BRIEF.md
# Group-Compressed Run-Length Sample Serialiser

This block sits between a capture memory and a byte-wide serial transmitter. It accepts captured samples one at a time through a valid/ready handshake. Samples arrive newest first, and the block keeps that order. It turns each sample into a short run of bytes. The sample is split into equal-width channel groups. Any group that software has switched off is dropped from the byte stream entirely, so the transmitted word shrinks as groups are disabled and the link time per sample falls with it.

When run-length mode is on, consecutive identical samples are merged. The block sends the sample once and follows it with a count word that carries the number of extra repetitions. The most significant bit of the highest transmitted byte tells the two kinds of word apart: it is set for a count word and clear for a sample. For this reason that bit is masked off every sample sent in this mode. A run longer than the count field can hold is broken into several sample-and-count pairs. A run is closed when a different sample arrives or when the sample flagged as last has been accepted.

Top module: `rle_sample_tx`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `s_ready` is 1.
- R2: Bit g of `grp_off` set to 1 disables group g, which occupies sample bits [g*GRP_W +: GRP_W]. A word is sent as one `GRP_W`-bit byte per enabled group, in ascending group order, with disabled groups left out. The number of bytes per word equals the number of zero bits in `grp_off`.
- R3: With every group disabled, samples are still accepted and no byte is ever presented.
- R4: With `rle_on` at 0, every accepted sample produces exactly one word, and words go out in the order the samples were accepted.
- R5: With `rle_on` at 1, every sample word is sent with the most significant bit of its highest transmitted byte at 0. Samples that become equal after this masking and after group removal count as identical.
- R6: With `rle_on` at 1, a run of N>1 identical samples is sent as the sample word followed by a count word. The count word has the top bit of its highest transmitted byte at 1, and its remaining bits hold N-1 as a little-endian value spread over the enabled bytes.
- R7: The largest count is 2^(B*GRP_W-1)-1, where B is the number of enabled bytes. A longer run is split into successive pairs. Each pair covers at most that count plus one samples. The final chunk omits its count word when it holds a single sample.
- R8: A run ends when a differing sample is accepted or when the sample with `s_last` is accepted. A run of one sample produces no count word.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values into the next cycle.
- R10: `s_ready` is 0 whenever a byte is being presented or a word is waiting to be serialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_off | input | NUM_GRP | Per-group disable, 1 = group omitted; held stable during a frame |
| rle_on | input | 1 | Run-length merging enable; held stable during a frame |
| s_valid | input | 1 | Sample available |
| s_data | input | NUM_GRP*GRP_W | Captured sample, group g in bits [g*GRP_W +: GRP_W] |
| s_last | input | 1 | Marks the final sample of a frame |
| s_ready | output | 1 | Sample accepted on this cycle when high together with s_valid |
| out_valid | output | 1 | Byte available for the transmitter |
| out_data | output | GRP_W | Byte value |
| out_ready | input | 1 | Transmitter takes the byte |

## Verification
The bench builds the block with four groups of two bits each. This gives count fields of 1, 3, 5 and 7 bits for one to four enabled groups, so a run overflows the largest count after only 2, 8, 32 or 128 samples. That lets every one of the sixteen disable masks be swept in both modes, with random run lengths and a stalling receiver, and lets split runs be reached at every word width. Directed frames add a single-sample frame, merging of samples that differ only in the masked top bit, and a run just past the widest limit.

// File: rtl/rle_tx_pkg.sv
package rle_tx_pkg;

    // Kind of a word handed from the run tracker to the byte shifter.
    typedef enum logic {
        WK_SAMPLE = 1'b0,
        WK_COUNT  = 1'b1
    } word_kind_e;

    localparam int unsigned MAX_GRP = 16;

    // Number of enabled groups among the first n, where a 1 disables.
    function automatic logic [4:0] count_enabled(input logic [MAX_GRP-1:0] off,
                                                 input int unsigned n);
        logic [4:0] c;
        c = '0;
        for (int unsigned i = 0; i < MAX_GRP; i++) begin
            if (i < n && !off[i]) c = c + 5'd1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rle_grp_packer.sv
module rle_grp_packer #(
    parameter int NUM_GRP = 4,
    parameter int GRP_W   = 8,
    localparam int WORD_W = NUM_GRP * GRP_W
) (
    input  logic [WORD_W-1:0]  raw,
    input  logic [NUM_GRP-1:0] grp_off,
    output logic [WORD_W-1:0]  pk_word
);
    // Enabled groups slide down so the lowest enabled one lands in byte 0.
    always_comb begin
        int unsigned k;
        k = 0;
        pk_word = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (!grp_off[g]) begin
                pk_word[k*GRP_W +: GRP_W] = raw[g*GRP_W +: GRP_W];
                k = k + 1;
            end
        end
    end
endmodule

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
    import rle_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int GRP_W  = 8,
    parameter int NB_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rle_on,
    input  logic [NB_W-1:0]   nb,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic [WORD_W-1:0] s_word,
    output logic              s_ready,
    output logic              w_valid,
    output word_kind_e        w_kind,
    output logic [WORD_W-1:0] w_data,
    input  logic              w_ready
);
    logic [WORD_W-1:0] flag_bit, max_cnt, smp_in;
    logic [WORD_W-1:0] run_smp, run_cnt, pend_smp, ow_data;
    logic              have_run, pend_valid, ow_valid, same, accept;
    word_kind_e        ow_kind;

    always_comb begin
        flag_bit = (nb == '0) ? '0 : (WORD_W'(1) << (int'(nb) * GRP_W - 1));
        max_cnt  = (nb == '0) ? '0 : (flag_bit - WORD_W'(1));
        smp_in   = rle_on ? (s_word & ~flag_bit) : s_word;
        same     = have_run && (smp_in == run_smp) && (run_cnt != max_cnt);
    end

    assign s_ready = w_ready && !ow_valid && !pend_valid;
    assign accept  = s_valid && s_ready;
    assign w_valid = ow_valid;
    assign w_kind  = ow_kind;
    assign w_data  = ow_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_run   <= 1'b0;
            pend_valid <= 1'b0;
            ow_valid   <= 1'b0;
            ow_kind    <= WK_SAMPLE;
            ow_data    <= '0;
            run_smp    <= '0;
            run_cnt    <= '0;
            pend_smp   <= '0;
        end else begin
            if (ow_valid && w_ready) begin
                if (pend_valid) begin
                    ow_kind    <= WK_SAMPLE;
                    ow_data    <= pend_smp;
                    pend_valid <= 1'b0;
                end else begin
                    ow_valid <= 1'b0;
                end
            end
            if (accept) begin
                if (!rle_on) begin
                    ow_valid <= 1'b1;
                    ow_kind  <= WK_SAMPLE;
                    ow_data  <= smp_in;
                    have_run <= 1'b0;
                end else if (same) begin
                    if (s_last) begin
                        ow_valid <= 1'b1;
                        ow_kind  <= WK_COUNT;
                        ow_data  <= (run_cnt + WORD_W'(1)) | flag_bit;
                        have_run <= 1'b0;
                        run_cnt  <= '0;
                    end else begin
                        run_cnt <= run_cnt + WORD_W'(1);
                    end
                end else begin
                    ow_valid <= 1'b1;
                    if (have_run && run_cnt != '0) begin
                        ow_kind    <= WK_COUNT;
                        ow_data    <= run_cnt | flag_bit;
                        pend_valid <= 1'b1;
                        pend_smp   <= smp_in;
                    end else begin
                        ow_kind <= WK_SAMPLE;
                        ow_data <= smp_in;
                    end
                    have_run <= !s_last;
                    run_smp  <= smp_in;
                    run_cnt  <= '0;
                end
            end
        end
    end

    // R7: the open run never counts past the field limit
    assert_run_limit_R7: assert property (@(posedge clk) disable iff (rst)
        have_run |-> run_cnt <= max_cnt);

    // R5: sample words in merging mode leave the marker bit clear
    assert_sample_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (ow_valid && ow_kind == WK_SAMPLE && rle_on) |-> (ow_data & flag_bit) == '0);

    // R6: a count word only appears in merging mode, is marked, and is nonzero
    assert_count_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (ow_valid && ow_kind == WK_COUNT) |->
            (rle_on && (ow_data & flag_bit) != '0 && (ow_data & max_cnt) != '0));

    // R8: a parked sample always waits behind the count that closes the old run
    assert_pend_order_R8: assert property (@(posedge clk) disable iff (rst)
        pend_valid |-> (ow_valid && ow_kind == WK_COUNT));
endmodule

// File: rtl/rle_byte_shifter.sv
module rle_byte_shifter #(
    parameter int NUM_GRP = 4,
    parameter int GRP_W   = 8,
    parameter int NB_W    = 3,
    localparam int WORD_W = NUM_GRP * GRP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NB_W-1:0]   nb,
    input  logic              w_valid,
    input  logic [WORD_W-1:0] w_data,
    output logic              w_ready,
    output logic              out_valid,
    output logic [GRP_W-1:0]  out_data,
    input  logic              out_ready
);
    logic [WORD_W-1:0] sh;
    logic [NB_W-1:0]   left;

    assign w_ready   = (left == '0);
    assign out_valid = (left != '0);
    assign out_data  = sh[GRP_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            left <= '0;
        end else if (w_valid && w_ready) begin
            sh   <= w_data;
            left <= nb;
        end else if (out_valid && out_ready) begin
            sh   <= sh >> GRP_W;
            left <= left - 1'b1;
        end
    end

    // R9: a stalled byte stays put
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R2: never more bytes outstanding than groups exist
    assert_left_range_R2: assert property (@(posedge clk) disable iff (rst)
        int'(left) <= NUM_GRP);
endmodule

// File: rtl/rle_sample_tx.sv
module rle_sample_tx
    import rle_tx_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int GRP_W   = 8,
    localparam int WORD_W = NUM_GRP * GRP_W,
    localparam int NB_W   = $clog2(NUM_GRP + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_GRP-1:0] grp_off,
    input  logic               rle_on,
    input  logic               s_valid,
    input  logic [WORD_W-1:0]  s_data,
    input  logic               s_last,
    output logic               s_ready,
    output logic               out_valid,
    output logic [GRP_W-1:0]   out_data,
    input  logic               out_ready
);
    logic [WORD_W-1:0]  pk_word, w_data;
    logic [NB_W-1:0]    nb;
    logic [MAX_GRP-1:0] off_ext;
    logic               w_valid, w_ready;
    word_kind_e         w_kind;

    always_comb begin
        off_ext = '1;
        off_ext[NUM_GRP-1:0] = grp_off;
        nb = NB_W'(count_enabled(off_ext, NUM_GRP));
    end

    rle_grp_packer #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_packer (
        .raw     (s_data),
        .grp_off (grp_off),
        .pk_word (pk_word)
    );

    rle_run_tracker #(.WORD_W(WORD_W), .GRP_W(GRP_W), .NB_W(NB_W)) u_tracker (
        .clk     (clk),
        .rst     (rst),
        .rle_on  (rle_on),
        .nb      (nb),
        .s_valid (s_valid),
        .s_last  (s_last),
        .s_word  (pk_word),
        .s_ready (s_ready),
        .w_valid (w_valid),
        .w_kind  (w_kind),
        .w_data  (w_data),
        .w_ready (w_ready)
    );

    rle_byte_shifter #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .NB_W(NB_W)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .nb        (nb),
        .w_valid   (w_valid),
        .w_data    (w_data),
        .w_ready   (w_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

    // R10: no new sample is taken while a byte is on offer
    assert_backpressure_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !s_ready);

    // R3: with every group off nothing is ever offered
    assert_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (nb == '0 && $stable(grp_off)) |=> !out_valid);
endmodule

// File: tb/rle_sample_tx_tb.sv
module rle_sample_tx_tb;
    localparam int NG = 4;
    localparam int GW = 2;
    localparam int WW = NG * GW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NG-1:0] grp_off = '0;
    logic          rle_on = 1'b0;
    logic          s_valid = 1'b0;
    logic [WW-1:0] s_data = '0;
    logic          s_last = 1'b0;
    logic          s_ready;
    logic          out_valid;
    logic [GW-1:0] out_data;
    logic          out_ready = 1'b0;

    always #2 clk = ~clk;

    rle_sample_tx #(.NUM_GRP(NG), .GRP_W(GW)) u_dut (
        .clk(clk), .rst(rst), .grp_off(grp_off), .rle_on(rle_on),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    int n_run = 0;
    int n_fail = 0;
    int hold_err = 0;
    int bp_err = 0;
    bit done = 0;
    logic [WW-1:0] smp_q[$];
    int exp_q[$];
    int got_q[$];
    logic pv = 0, pr = 0;
    logic [GW-1:0] pd = '0;
    logic [15:0] lfsr = 16'hACE1;
    int unsigned seed = 32'd12345;

    // Receiver: random stalls, byte capture, hold and back-pressure watch.
    always @(negedge clk) begin
        if (!rst) begin
            if (pv && !pr && (!out_valid || out_data != pd)) hold_err++;
            if (out_valid && s_ready) bp_err++;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = (lfsr[1:0] != 2'b00);
        if (!rst && out_valid && out_ready) got_q.push_back(int'(out_data));
        pv = out_valid;
        pr = out_ready;
        pd = out_data;
    end

    function automatic void push_word(int w, int nb);
        for (int b = 0; b < nb; b++) exp_q.push_back((w >> (b * GW)) & ((1 << GW) - 1));
    endfunction

    function automatic void build_exp(logic [NG-1:0] off_v, bit rle_v);
        int nb = 0;
        int cw[$];
        exp_q.delete();
        for (int g = 0; g < NG; g++) if (!off_v[g]) nb++;
        if (nb == 0) return;
        foreach (smp_q[i]) begin
            int v = 0;
            int k = 0;
            for (int g = 0; g < NG; g++) begin
                if (!off_v[g]) begin
                    v = v | (((int'(smp_q[i]) >> (g * GW)) & ((1 << GW) - 1)) << (k * GW));
                    k++;
                end
            end
            cw.push_back(v);
        end
        if (!rle_v) begin
            foreach (cw[i]) push_word(cw[i], nb);
        end else begin
            int flag = 1 << (nb * GW - 1);
            int mx = flag - 1;
            int i = 0;
            foreach (cw[j]) cw[j] = cw[j] & mx;
            while (i < cw.size()) begin
                int j = i;
                int len;
                while (j < cw.size() && cw[j] == cw[i]) j++;
                len = j - i;
                while (len > 0) begin
                    int c = (len > mx + 1) ? mx + 1 : len;
                    push_word(cw[i], nb);
                    if (c > 1) push_word((c - 1) | flag, nb);
                    len = len - c;
                end
                i = j;
            end
        end
    endfunction

    task automatic run_frame(input logic [NG-1:0] off_v, input bit rle_v, input string tag);
        int w = 0;
        int bad = -1;
        grp_off = off_v;
        rle_on = rle_v;
        build_exp(off_v, rle_v);
        got_q.delete();
        hold_err = 0;
        bp_err = 0;
        foreach (smp_q[i]) begin
            s_valid = 1'b1;
            s_data = smp_q[i];
            s_last = (i == smp_q.size() - 1);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last = 1'b0;
        while (got_q.size() < exp_q.size() && w < 4000) begin
            @(negedge clk);
            w++;
        end
        repeat (12) @(negedge clk);
        n_run++;
        if (got_q.size() != exp_q.size()) begin
            n_fail++;
            $display("FAIL %s off=%b rle=%0d: byte count actual %0d expected %0d",
                     tag, off_v, rle_v, got_q.size(), exp_q.size());
        end else begin
            foreach (exp_q[i]) if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
            if (bad >= 0) begin
                n_fail++;
                $display("FAIL %s off=%b rle=%0d: byte %0d actual %0h expected %0h",
                         tag, off_v, rle_v, bad, got_q[bad], exp_q[bad]);
            end
        end
        n_run++;
        if (hold_err != 0) begin
            n_fail++;
            $display("FAIL R9 off=%b: stalled byte changed, actual %0d events expected 0", off_v, hold_err);
        end
        n_run++;
        if (bp_err != 0) begin
            n_fail++;
            $display("FAIL R10 off=%b: ready while byte offered, actual %0d events expected 0", off_v, bp_err);
        end
    endtask

    function automatic int unsigned next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 16;
    endfunction

    task automatic gen_random(input int n);
        smp_q.delete();
        while (smp_q.size() < n) begin
            int unsigned r = next_rand();
            int len = 1 + int'(r % 11);
            logic [WW-1:0] v = WW'(next_rand());
            for (int k = 0; k < len && smp_q.size() < n; k++) smp_q.push_back(v);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || s_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 reset: out_valid=%b s_ready=%b expected 0 1", out_valid, s_ready);
        end
        // Sweep every disable mask in both modes (R2 R3 R4 R5 R6 R7 R8).
        for (int m = 0; m < (1 << NG); m++) begin
            for (int r = 0; r < 2; r++) begin
                string tag;
                gen_random(24);
                if (m == (1 << NG) - 1) tag = "R3";
                else if (r == 1) tag = "R2 R5 R6 R7 R8";
                else tag = "R2 R4";
                run_frame(NG'(m), bit'(r), tag);
            end
        end
        // R7: run of 130 just past the widest limit of 127.
        smp_q.delete();
        for (int k = 0; k < 130; k++) smp_q.push_back(8'h35);
        run_frame(4'b0000, 1'b1, "R7");
        // R7: one group, limit 1, top bit of sample set.
        smp_q.delete();
        for (int k = 0; k < 5; k++) smp_q.push_back(8'hF3);
        run_frame(4'b1110, 1'b1, "R5 R7");
        // R8: single sample frame emits no count word.
        smp_q.delete();
        smp_q.push_back(8'h5A);
        run_frame(4'b0000, 1'b1, "R8");
        // R5: samples differing only in the marker bit merge into one run.
        smp_q.delete();
        smp_q.push_back(8'h80);
        smp_q.push_back(8'h00);
        smp_q.push_back(8'h11);
        run_frame(4'b0000, 1'b1, "R5 R6");
        // R4: identical samples are not merged when merging is off.
        smp_q.delete();
        for (int k = 0; k < 6; k++) smp_q.push_back(8'hC6);
        run_frame(4'b0101, 1'b0, "R4");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule